// File: doc/BRIEF.md
# Externally Triggered Shutter Line Latch

This block times an electronic shutter from an external trigger. It keeps a line counter that is restarted by the vertical reference and advanced by the horizontal reference. A falling edge on the active-low trigger input arms a capture. At the next rising edge of the horizontal reference the block latches the number of the line that starts at that edge. The latched line sets the last line on which the overflow-drain (OFD) pulse enable is asserted. Pulses begin at a fixed start line in each field.

The latched line is stored as an offset from the start line of the field it fell in. That offset is then applied in both fields of every later frame, so the two field parities get the same storage time. Captures that land on a few lines just before a start line are discarded. A capture that would make the shutter faster (a larger offset) takes effect only after one further full field. A capture that keeps the speed or makes it slower takes effect at once. When the mode input is low, the block holds its stored state cleared and outputs no pulses. A new trigger is then needed before pulses resume, and the same holds after reset.

Top module: `ext_shutter_latch`

## Requirements
- R1: The line counter is 1 after reset. A rising edge of `vd_ref` sets it to 1 and takes priority over `hd_ref`. Each rising edge of `hd_ref` advances it by one, and it returns to 1 after the last line of the frame (525 lines when `pal_sel` is 0).
- R2: While `ext_en` is 0, `ofd_en` is 0 and `line_hold` is cleared to 0. After reset, or after `ext_en` returns to 1, `ofd_en` stays 0 until a capture has been accepted.
- R3: A falling edge of `trig_n` arms a capture, which is taken at the next rising edge of `hd_ref`. A falling edge seen in the same clock as that `hd_ref` edge is also taken at that edge. The captured value is the line starting at that edge, and `line_hold` shows it from the following clock on.
- R4: A capture landing on line A-2, B-3 or B-2, where A and B are the field start lines, is discarded: `line_hold` and the stored offset stay unchanged. With `pal_sel` = 0 these are lines 18, 280 and 281.
- R5: With `pal_sel` = 0 the start lines are A = 20 and B = 283. Field one covers lines A to B-1 and field two covers line B to the end of the frame plus lines 1 to A-1. The offset of a line is its distance from the start of its field.
- R6: `ofd_en` is 1 exactly when `ext_en` is 1, a capture is stored, and the current line's offset is at most the stored offset. The same rule applies in both fields.
- R7: The first accepted capture, and any capture whose offset does not exceed the stored one, replaces the stored offset immediately. It already applies to the line on which it was captured.
- R8: A capture with a larger offset is held pending. The old offset applies for the rest of the current field and all of the next one. The new offset applies from the start of the field after that.
- R9: A newer capture replaces a pending one and restarts its one-field delay.
- R10: With `pal_sel` = 1 the frame has 625 lines, the start lines are A = 22 and B = 335, and captures on lines 20, 332 and 333 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_ref | input | 1 | Horizontal reference; its rising edge starts a line |
| vd_ref | input | 1 | Vertical reference; its rising edge restarts the frame |
| pal_sel | input | 1 | TV system: 0 for the 525-line system, 1 for the 625-line system |
| ext_en | input | 1 | Enables the externally triggered shutter mode |
| trig_n | input | 1 | Shutter trigger; a falling edge arms a capture |
| ofd_en | output | 1 | OFD pulse enable for the current line |
| line_hold | output | 10 | Most recently accepted captured line number |

## Verification
Two functions can fall in the same clock here: the arming edge of the trigger and the horizontal edge that takes the capture. The bench drives `trig_n` low in the same clock in which `hd_ref` rises. It expects `line_hold` to show the new line one clock later, with no wait for a further line. A per-clock behavioural model also covers the case where a field-start edge commits a pending offset in the same clock as a new capture. In that case the commit is applied first, and the capture is then compared against the committed value.

// File: rtl/xsh_pkg.sv
package xsh_pkg;

    localparam int LINE_W      = 10;
    localparam int NTSC_TOTAL  = 525;
    localparam int PAL_TOTAL   = 625;
    localparam int NTSC_FIRST  = 20;
    localparam int PAL_FIRST   = 22;

    typedef logic [LINE_W-1:0] line_t;

    // position of a line inside its shutter field
    typedef struct packed {
        logic  second;
        line_t rel;
    } fpos_t;

    // stored shutter state
    typedef struct packed {
        logic  valid;
        line_t eff;
        logic  pend_v;
        logic  pend_age;
        line_t pend;
        line_t hold;
    } store_t;

    function automatic line_t frame_lines(input logic pal);
        return pal ? line_t'(PAL_TOTAL) : line_t'(NTSC_TOTAL);
    endfunction

    function automatic line_t start_a(input logic pal);
        return pal ? line_t'(PAL_FIRST) : line_t'(NTSC_FIRST);
    endfunction

    function automatic line_t start_b(input logic pal);
        return (frame_lines(pal) >> 1) + start_a(pal) + line_t'(1);
    endfunction

    function automatic fpos_t locate(input line_t ln, input logic pal);
        fpos_t p;
        line_t a;
        line_t b;
        a = start_a(pal);
        b = start_b(pal);
        if (ln >= a && ln < b) begin
            p.second = 1'b0;
            p.rel    = ln - a;
        end else if (ln >= b) begin
            p.second = 1'b1;
            p.rel    = ln - b;
        end else begin
            p.second = 1'b1;
            p.rel    = ln + frame_lines(pal) - b;
        end
        return p;
    endfunction

    function automatic logic in_dead_zone(input line_t ln, input logic pal);
        line_t a;
        line_t b;
        a = start_a(pal);
        b = start_b(pal);
        return (ln == a - line_t'(2)) || (ln == b - line_t'(3)) || (ln == b - line_t'(2));
    endfunction

endpackage

// File: rtl/xsh_line_tracker.sv
module xsh_line_tracker
    import xsh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hd_ref,
    input  logic  vd_ref,
    input  logic  pal_sel,
    output line_t line_q,
    output line_t line_nx,
    output logic  hd_rise,
    output logic  fstart
);

    logic hd_d;
    logic vd_d;
    logic vd_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_d   <= 1'b0;
            vd_d   <= 1'b0;
            line_q <= line_t'(1);
        end else begin
            hd_d   <= hd_ref;
            vd_d   <= vd_ref;
            line_q <= line_nx;
        end
    end

    always_comb begin
        hd_rise = hd_ref & ~hd_d;
        vd_rise = vd_ref & ~vd_d;
        line_nx = line_q;
        if (vd_rise) begin
            line_nx = line_t'(1);
        end else if (hd_rise) begin
            line_nx = (line_q >= frame_lines(pal_sel)) ? line_t'(1) : line_q + line_t'(1);
        end
        fstart = (vd_rise | hd_rise) &&
                 (line_nx == start_a(pal_sel) || line_nx == start_b(pal_sel));
    end

    a_r1_line_nonzero: assert property (@(posedge clk) disable iff (rst)
        line_q != '0);

    a_r1_line_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hd_rise) && !$past(vd_rise) &&
         $past(line_q) < frame_lines(pal_sel))
        |-> line_q == $past(line_q) + line_t'(1));

    a_r1_vd_restart: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(vd_rise)) |-> line_q == line_t'(1));

endmodule

// File: rtl/xsh_trig_capture.sv
module xsh_trig_capture
    import xsh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ext_en,
    input  logic  trig_n,
    input  logic  hd_rise,
    input  line_t line_nx,
    input  logic  pal_sel,
    output logic  cap_fire,
    output line_t cap_line
);

    logic trig_d;
    logic arm;
    logic trig_fall;

    assign trig_fall = ~trig_n & trig_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_d <= 1'b1;
            arm    <= 1'b0;
        end else begin
            trig_d <= trig_n;
            if (!ext_en || hd_rise) begin
                arm <= 1'b0;
            end else if (trig_fall) begin
                arm <= 1'b1;
            end
        end
    end

    always_comb begin
        cap_line = line_nx;
        cap_fire = ext_en && hd_rise && (arm || trig_fall) &&
                   !in_dead_zone(line_nx, pal_sel);
    end

    // R3: an edge away from the horizontal edge leaves the capture armed
    a_r3_arm_holds: assert property (@(posedge clk) disable iff (rst)
        (ext_en && trig_fall && !hd_rise) |=> arm);

endmodule

// File: rtl/xsh_shutter_store.sv
module xsh_shutter_store
    import xsh_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ext_en,
    input  logic  pal_sel,
    input  logic  fstart,
    input  logic  cap_fire,
    input  line_t cap_line,
    output logic  valid,
    output line_t eff_rel,
    output line_t line_hold
);

    store_t st;
    store_t nx;
    fpos_t  cap_pos;
    line_t  cap_rel;

    always_comb begin
        cap_pos = locate(cap_line, pal_sel);
        cap_rel = cap_pos.rel;
        nx      = st;
        if (!ext_en) begin
            nx = '0;
        end else begin
            // field start: age or commit a pending faster setting
            if (fstart && st.pend_v) begin
                if (st.pend_age) begin
                    nx.eff      = st.pend;
                    nx.pend_v   = 1'b0;
                    nx.pend_age = 1'b0;
                end else begin
                    nx.pend_age = 1'b1;
                end
            end
            if (cap_fire) begin
                nx.hold = cap_line;
                if (!nx.valid || cap_rel <= nx.eff) begin
                    nx.valid    = 1'b1;
                    nx.eff      = cap_rel;
                    nx.pend_v   = 1'b0;
                    nx.pend_age = 1'b0;
                end else begin
                    nx.pend_v   = 1'b1;
                    nx.pend     = cap_rel;
                    nx.pend_age = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nx;
        end
    end

    assign valid     = st.valid;
    assign eff_rel   = st.eff;
    assign line_hold = st.hold;

    a_r2_cleared_when_off: assert property (@(posedge clk) disable iff (rst)
        !ext_en |=> (!st.valid && !st.pend_v));

    a_r3_hold_follows_capture: assert property (@(posedge clk) disable iff (rst)
        (ext_en && cap_fire) |=> line_hold == $past(cap_line));

    a_r7_slower_now: assert property (@(posedge clk) disable iff (rst)
        (ext_en && cap_fire && !fstart && (!st.valid || cap_rel <= st.eff))
        |=> (st.valid && st.eff == $past(cap_rel)));

    a_r8_faster_waits: assert property (@(posedge clk) disable iff (rst)
        (ext_en && st.valid && cap_fire && !fstart && cap_rel > st.eff)
        |=> st.eff == $past(st.eff));

    a_r8_commit_after_age: assert property (@(posedge clk) disable iff (rst)
        (ext_en && fstart && st.pend_v && st.pend_age && !cap_fire)
        |=> st.eff == $past(st.pend));

endmodule

// File: rtl/ext_shutter_latch.sv
module ext_shutter_latch
    import xsh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hd_ref,
    input  logic              vd_ref,
    input  logic              pal_sel,
    input  logic              ext_en,
    input  logic              trig_n,
    output logic              ofd_en,
    output logic [LINE_W-1:0] line_hold
);

    line_t line_q;
    line_t line_nx;
    logic  hd_rise;
    logic  fstart;
    logic  cap_fire;
    line_t cap_line;
    logic  valid;
    line_t eff_rel;
    fpos_t cur_pos;

    xsh_line_tracker u_track (
        .clk     (clk),
        .rst     (rst),
        .hd_ref  (hd_ref),
        .vd_ref  (vd_ref),
        .pal_sel (pal_sel),
        .line_q  (line_q),
        .line_nx (line_nx),
        .hd_rise (hd_rise),
        .fstart  (fstart)
    );

    xsh_trig_capture u_cap (
        .clk      (clk),
        .rst      (rst),
        .ext_en   (ext_en),
        .trig_n   (trig_n),
        .hd_rise  (hd_rise),
        .line_nx  (line_nx),
        .pal_sel  (pal_sel),
        .cap_fire (cap_fire),
        .cap_line (cap_line)
    );

    xsh_shutter_store u_store (
        .clk       (clk),
        .rst       (rst),
        .ext_en    (ext_en),
        .pal_sel   (pal_sel),
        .fstart    (fstart),
        .cap_fire  (cap_fire),
        .cap_line  (cap_line),
        .valid     (valid),
        .eff_rel   (eff_rel),
        .line_hold (line_hold)
    );

    always_comb begin
        cur_pos = locate(line_q, pal_sel);
        ofd_en  = ext_en && valid && (cur_pos.rel <= eff_rel);
    end

    // R6: the start line of any field always carries a pulse once a value is held
    a_r6_pulse_on_start: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fstart) && ext_en && valid) |-> ofd_en);

    // R4: a newly shown captured line never lies in the rejected window
    a_r4_no_dead_line: assert property (@(posedge clk) disable iff (rst)
        (!$stable(line_hold) && ext_en && $past(ext_en))
        |-> !in_dead_zone(line_hold, pal_sel));

endmodule

// File: tb/ext_shutter_latch_tb_top.sv
module ext_shutter_latch_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hd = 1'b0;
    logic       vd = 1'b0;
    logic       pal = 1'b0;
    logic       ext = 1'b1;
    logic       trig = 1'b1;
    logic       ofd_en;
    logic [9:0] line_hold;

    int n_chk = 0;
    int n_fail = 0;
    int cur = 1;
    bit done = 0;

    always #4 clk = ~clk;

    ext_shutter_latch dut_i (
        .clk       (clk),
        .rst       (rst),
        .hd_ref    (hd),
        .vd_ref    (vd),
        .pal_sel   (pal),
        .ext_en    (ext),
        .trig_n    (trig),
        .ofd_en    (ofd_en),
        .line_hold (line_hold)
    );

    // ---------------- behavioural reference model ----------------
    int m_line, m_eff, m_prel, m_hold;
    bit m_hdp, m_vdp, m_trp, m_arm, m_valid, m_pv, m_age;

    function automatic int tot_of(input bit p);
        return p ? 625 : 525;
    endfunction
    function automatic int sa_of(input bit p);
        return p ? 22 : 20;
    endfunction
    function automatic int sb_of(input bit p);
        return tot_of(p) / 2 + sa_of(p) + 1;
    endfunction
    function automatic int relof(input int ln, input bit p);
        if (ln >= sa_of(p) && ln < sb_of(p)) return ln - sa_of(p);
        if (ln >= sb_of(p)) return ln - sb_of(p);
        return ln + tot_of(p) - sb_of(p);
    endfunction

    always @(posedge clk) begin
        int  nl, r;
        bit  hr, vr, tf, fs, dead;
        if (rst) begin
            m_hdp = 0; m_vdp = 0; m_trp = 1; m_line = 1; m_arm = 0;
            m_valid = 0; m_eff = 0; m_pv = 0; m_age = 0; m_prel = 0; m_hold = 0;
        end else begin
            hr = hd && !m_hdp;
            vr = vd && !m_vdp;
            tf = !trig && m_trp;
            if (vr) nl = 1;
            else if (hr) nl = (m_line == tot_of(pal)) ? 1 : m_line + 1;
            else nl = m_line;
            fs = (vr || hr) && (nl == sa_of(pal) || nl == sb_of(pal));
            if (!ext) begin
                m_arm = 0; m_valid = 0; m_eff = 0; m_pv = 0; m_age = 0; m_prel = 0; m_hold = 0;
            end else begin
                if (fs && m_pv) begin
                    if (m_age) begin m_eff = m_prel; m_pv = 0; m_age = 0; end
                    else m_age = 1;
                end
                if (hr) begin
                    dead = (nl == sa_of(pal) - 2) || (nl == sb_of(pal) - 3) || (nl == sb_of(pal) - 2);
                    if ((m_arm || tf) && !dead) begin
                        r = relof(nl, pal);
                        m_hold = nl;
                        if (!m_valid || r <= m_eff) begin
                            m_valid = 1; m_eff = r; m_pv = 0; m_age = 0;
                        end else begin
                            m_pv = 1; m_prel = r; m_age = 0;
                        end
                    end
                    m_arm = 0;
                end else if (tf) begin
                    m_arm = 1;
                end
            end
            m_line = nl;
            m_hdp = hd; m_vdp = vd; m_trp = trig;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 ofd_en vs model", int'(ofd_en),
                int'(ext && m_valid && (relof(m_line, pal) <= m_eff)));
            chk("R3 line_hold vs model", int'(line_hold), m_hold);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(negedge clk) hd = 1'b1;
        @(negedge clk) hd = 1'b0;
        repeat (2) @(negedge clk);
        cur = (cur == tot_of(pal)) ? 1 : cur + 1;
    endtask

    task automatic goto(input int target);
        while (cur != target) tick();
    endtask

    task automatic vpulse();
        @(negedge clk) vd = 1'b1;
        @(negedge clk) vd = 1'b0;
        repeat (2) @(negedge clk);
        cur = 1;
    endtask

    task automatic arm_trig();
        @(negedge clk) trig = 1'b0;
        @(negedge clk) trig = 1'b1;
    endtask

    task automatic trig_with_hd();
        @(negedge clk) begin trig = 1'b0; hd = 1'b1; end
        @(negedge clk) begin trig = 1'b1; hd = 1'b0; end
        repeat (2) @(negedge clk);
        cur = (cur == tot_of(pal)) ? 1 : cur + 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 reset ofd_en", int'(ofd_en), 0);
        chk("R2 reset line_hold", int'(line_hold), 0);

        // NTSC frame, first capture
        vpulse();
        goto(40);
        chk("R2 no pulse before capture", int'(ofd_en), 0);
        arm_trig();
        tick();
        chk("R3 capture at line 41", int'(line_hold), 41);
        chk("R7 pulse on capture line", int'(ofd_en), 1);
        tick();
        chk("R6 line 42 beyond end", int'(ofd_en), 0);
        goto(283);
        chk("R5 field two start pulse", int'(ofd_en), 1);
        goto(304);
        chk("R6 field two last pulse", int'(ofd_en), 1);
        tick();
        chk("R6 field two after end", int'(ofd_en), 0);

        // wrap and dead lines
        goto(17);
        arm_trig();
        tick();
        chk("R1 wrap then line 18 rejected", int'(line_hold), 41);
        chk("R4 line 18 no pulse", int'(ofd_en), 0);
        goto(279);
        arm_trig();
        tick();
        chk("R4 line 280 rejected", int'(line_hold), 41);

        // slower setting applies at once
        goto(29);
        arm_trig();
        tick();
        chk("R7 capture line 30", int'(line_hold), 30);
        chk("R7 pulse on 30", int'(ofd_en), 1);
        tick();
        chk("R7 no pulse on 31", int'(ofd_en), 0);

        // faster setting deferred one field
        goto(59);
        arm_trig();
        tick();
        chk("R8 capture line 60 shown", int'(line_hold), 60);
        chk("R8 old value still used", int'(ofd_en), 0);
        goto(293);
        chk("R8 next field old end", int'(ofd_en), 1);
        tick();
        chk("R8 next field old end+1", int'(ofd_en), 0);
        goto(60);
        chk("R8 new end applied", int'(ofd_en), 1);
        tick();
        chk("R8 new end+1", int'(ofd_en), 0);

        // replacement of a pending value
        goto(99);
        arm_trig();
        tick();
        goto(149);
        arm_trig();
        tick();
        goto(323);
        chk("R9 field two keeps old", int'(ofd_en), 1);
        tick();
        chk("R9 field two old end+1", int'(ofd_en), 0);
        goto(150);
        chk("R9 newer pending used", int'(ofd_en), 1);
        tick();
        chk("R9 newer end+1", int'(ofd_en), 0);

        // trigger edge and horizontal edge in the same clock
        goto(199);
        trig_with_hd();
        chk("R3 same-clock capture", int'(line_hold), 200);

        // mode off clears state
        @(negedge clk) ext = 1'b0;
        @(negedge clk);
        chk("R2 off ofd_en", int'(ofd_en), 0);
        chk("R2 off line_hold", int'(line_hold), 0);
        goto(24);
        @(negedge clk) ext = 1'b1;
        tick();
        chk("R2 re-enabled no pulse", int'(ofd_en), 0);

        // 625-line system
        @(negedge clk) pal = 1'b1;
        vpulse();
        goto(339);
        arm_trig();
        tick();
        chk("R10 capture line 340", int'(line_hold), 340);
        chk("R10 pulse on 340", int'(ofd_en), 1);
        tick();
        chk("R10 no pulse on 341", int'(ofd_en), 0);
        goto(19);
        arm_trig();
        tick();
        chk("R10 line 20 rejected", int'(line_hold), 340);
        goto(27);
        chk("R10 field one end", int'(ofd_en), 1);
        tick();
        chk("R10 field one end+1", int'(ofd_en), 0);
        goto(332);
        arm_trig();
        tick();
        chk("R10 line 333 rejected", int'(line_hold), 340);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule